// File: doc/BRIEF.md
# Multichannel Serial Sample Output Formatter

This block turns one 12-bit sample per channel per sample period into eight parallel serial bit streams, one output line per channel, together with a frame clock at the sample rate and a bit clock for the receiver. It runs from one fast clock at 12 times the sample rate. Each fast-clock cycle is one bit window, and twelve windows make one frame. Every lane shares the same window counter, so all channels move one bit at a time in lockstep.

Configuration inputs choose between the following: a double-data-rate bit clock, with four selectable phases, and a single-data-rate bit clock, with two selectable alignments. They also choose the bit order on the line, and whether the sample goes out in offset binary or in two's complement. A per-channel power-down input holds a lane's data at zero while both clocks keep running. Each bit window carries two bit-clock levels, one for each half of the window. This lets the block express clock edges in the middle of a window and at its boundary without a faster clock.

Top module: `lvds_out_fmt`

## Requirements
- R1: The window index steps 0,1,...,11 and wraps to 0. `fclk_o` is 1 in windows 0 to 5 and 0 in windows 6 to 11, so it has a period of 12 clock cycles.
- R2: Samples, power-down bits and all configuration inputs are captured only on the clock edge that leaves window 11, and they apply to the whole following frame. Changes at any other edge have no effect on the outputs.
- R3: With `lsb_first_i`=0, window w of a lane carries sample bit 11-w. With `lsb_first_i`=1, it carries bit w. All lanes present the same window index in the same cycle.
- R4: With `twos_comp_i`=1, the sample's bit 11 is inverted before it is serialized. All other bits are unchanged.
- R5: In double-rate mode (`sdr_en_i`=0), `bclk_o[0]` is the bit-clock level in the first half of a window and `bclk_o[1]` is the level in the second half. Number the half-slot s = 2*(w mod 2)+h and let d = (s - `ddr_phase_i`) mod 4. The level is 1 exactly when d is 1 or 2. Phase 0 therefore rises in the middle of even windows and falls in the middle of odd windows.
- R6: In single-rate mode (`sdr_en_i`=1), the bit clock completes one period per window. With `sdr_fall_i`=0, `bclk_o`=2'b10 (low then high). With `sdr_fall_i`=1, `bclk_o`=2'b01 (high then low).
- R7: A lane whose `pwrdn_i` bit is 1 at capture drives 0 in every window of that frame. The clocks and the other lanes are unaffected.
- R8: While `rst_ni`=0, the block sits in window 11. Its captured words are zero and its configuration is all-zero (double rate, phase 0, MSB first, offset binary, no power-down), so data and `fclk_o` are 0. The first clock edge after release captures the inputs and starts window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-window clock, 12 times the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | NCH*BITS | Channel c sample in bits [c*BITS +: BITS], offset binary |
| pwrdn_i | input | NCH | Per-lane power-down, 1 = lane held at 0 |
| sdr_en_i | input | 1 | 1 = single-rate bit clock, 0 = double-rate |
| sdr_fall_i | input | 1 | Single-rate alignment select |
| ddr_phase_i | input | 2 | Double-rate bit-clock phase |
| lsb_first_i | input | 1 | 1 = LSB first on the line |
| twos_comp_i | input | 1 | 1 = two's-complement output coding |
| data_o | output | NCH | Serial data, one line per channel |
| fclk_o | output | 1 | Frame clock |
| bclk_o | output | 2 | Bit-clock level: [0] first half, [1] second half of window |

## Verification
The hardest condition to reach is the claim that an input change inside a frame never leaks into the words being sent. A change could slip in at the wrong edge and still look plausible at the ports. The stimulus therefore drives fresh random samples, power-down bits and configuration after every window except the last one of each frame. It puts the intended values on the inputs only in the half cycle before the capture edge, so any capture at the wrong edge shows up as a data or clock mismatch. Directed frames sweep all four double-rate phases, both single-rate alignments, the MSB-only and all-ones-below-MSB codes, and lanes in power-down.

// File: rtl/lvds_fmt_pkg.sv
package lvds_fmt_pkg;
  typedef struct packed {
    logic       sdr_en;
    logic       sdr_fall;
    logic [1:0] ddr_phase;
    logic       lsb_first;
    logic       twos_comp;
  } fmt_cfg_t;

  localparam fmt_cfg_t CFG_RST = '0;
endpackage

// File: rtl/lvds_fmt_slot_ctr.sv
module lvds_fmt_slot_ctr #(
  parameter int BITS = 12,
  localparam int CW = $clog2(BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          load_o
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= LAST;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign load_o = (cnt_q == LAST);

  p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/lvds_fmt_clk_gen.sv
module lvds_fmt_clk_gen
  import lvds_fmt_pkg::*;
#(
  parameter int BITS = 12,
  localparam int CW = $clog2(BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  fmt_cfg_t      cfg_i,
  output logic          fclk_o,
  output logic [1:0]    bclk_o
);
  localparam logic [CW-1:0] HALF = CW'(BITS / 2);

  logic [1:0] d0, d1;

  always_comb begin
    // half-slot index minus phase, modulo 4
    d0 = {cnt_i[0], 1'b0} - cfg_i.ddr_phase;
    d1 = {cnt_i[0], 1'b1} - cfg_i.ddr_phase;
    if (cfg_i.sdr_en) bclk_o = cfg_i.sdr_fall ? 2'b01 : 2'b10;
    else              bclk_o = {d1[1] ^ d1[0], d0[1] ^ d0[0]};
  end

  assign fclk_o = (cnt_i < HALF);

  p_fclk_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fclk_o) |-> (cnt_i == '0));
  p_sdr_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.sdr_en |-> (bclk_o[0] != bclk_o[1]));
  p_ddr_mid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.sdr_en |-> ((bclk_o[0] != bclk_o[1]) == !cfg_i.ddr_phase[0]));
endmodule

// File: rtl/lvds_fmt_lane.sv
module lvds_fmt_lane #(
  parameter int BITS = 12,
  localparam int CW = $clog2(BITS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic            lsb_first_i,
  input  logic            twos_comp_i,
  input  logic            pwrdn_i,
  input  logic [BITS-1:0] sample_i,
  output logic            data_o
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [BITS-1:0] word_q;
  logic            pd_q;
  logic [CW-1:0]   idx;
  logic            flip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      pd_q   <= 1'b0;
    end else if (load_i) begin
      word_q <= sample_i;
      pd_q   <= pwrdn_i;
    end
  end

  always_comb begin
    idx    = lsb_first_i ? cnt_i : LAST - cnt_i;
    flip   = twos_comp_i && (idx == LAST);
    data_o = !pd_q && (word_q[idx] ^ flip);
  end

  p_word_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(word_q) && $stable(pd_q)));
endmodule

// File: rtl/lvds_out_fmt.sv
module lvds_out_fmt
  import lvds_fmt_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int BITS = 12,
  localparam int CW = $clog2(BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NCH*BITS-1:0] sample_i,
  input  logic [NCH-1:0]      pwrdn_i,
  input  logic                sdr_en_i,
  input  logic                sdr_fall_i,
  input  logic [1:0]          ddr_phase_i,
  input  logic                lsb_first_i,
  input  logic                twos_comp_i,
  output logic [NCH-1:0]      data_o,
  output logic                fclk_o,
  output logic [1:0]          bclk_o
);
  logic [CW-1:0] cnt;
  logic          load;
  fmt_cfg_t      cfg_q;

  lvds_fmt_slot_ctr #(.BITS(BITS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .load_o (load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (load) cfg_q <= '{sdr_en: sdr_en_i, sdr_fall: sdr_fall_i,
                              ddr_phase: ddr_phase_i, lsb_first: lsb_first_i,
                              twos_comp: twos_comp_i};
  end

  lvds_fmt_clk_gen #(.BITS(BITS)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt),
    .cfg_i  (cfg_q),
    .fclk_o (fclk_o),
    .bclk_o (bclk_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    lvds_fmt_lane #(.BITS(BITS)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load),
      .cnt_i       (cnt),
      .lsb_first_i (cfg_q.lsb_first),
      .twos_comp_i (cfg_q.twos_comp),
      .pwrdn_i     (pwrdn_i[c]),
      .sample_i    (sample_i[c*BITS +: BITS]),
      .data_o      (data_o[c])
    );
  end

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(cfg_q));
endmodule

// File: tb/sim_lvds_out_fmt.sv
module sim_lvds_out_fmt;
  localparam int NCH  = 8;
  localparam int BITS = 12;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic [NCH*BITS-1:0] sample_i = '0;
  logic [NCH-1:0]      pwrdn_i = '0;
  logic                sdr_en_i = 1'b0, sdr_fall_i = 1'b0;
  logic [1:0]          ddr_phase_i = 2'd0;
  logic                lsb_first_i = 1'b0, twos_comp_i = 1'b0;
  logic [NCH-1:0]      data_o;
  logic                fclk_o;
  logic [1:0]          bclk_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lvds_out_fmt #(.NCH(NCH), .BITS(BITS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .pwrdn_i(pwrdn_i),
    .sdr_en_i(sdr_en_i), .sdr_fall_i(sdr_fall_i), .ddr_phase_i(ddr_phase_i),
    .lsb_first_i(lsb_first_i), .twos_comp_i(twos_comp_i),
    .data_o(data_o), .fclk_o(fclk_o), .bclk_o(bclk_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(logic [11:0] w, int win, logic lsb, logic twos, logic pd);
    int idx = lsb ? win : 11 - win;
    logic [11:0] v = w;
    if (twos) v[11] = ~v[11];
    return pd ? 1'b0 : v[idx];
  endfunction

  function automatic logic [1:0] exp_bclk(int win, logic sdr, logic fall, logic [1:0] ph);
    logic [1:0] r;
    if (sdr) return fall ? 2'b01 : 2'b10;
    for (int h = 0; h < 2; h++) begin
      int s = 2 * (win % 2) + h;
      int d = (s - int'(ph) + 4) % 4;
      r[h] = (d == 1 || d == 2);
    end
    return r;
  endfunction

  task automatic junk();
    for (int c = 0; c < NCH; c++) sample_i[c*BITS +: BITS] = 12'($urandom);
    pwrdn_i = NCH'($urandom);
    {sdr_en_i, sdr_fall_i, ddr_phase_i, lsb_first_i, twos_comp_i} = 6'($urandom);
  endtask

  // Called at the negedge before a capture edge; checks all 12 windows.
  task automatic run_frame(input logic [NCH*BITS-1:0] smp, input logic [NCH-1:0] pd,
                           input logic sdr, input logic fall, input logic [1:0] ph,
                           input logic lsb, input logic twos);
    sample_i = smp; pwrdn_i = pd; sdr_en_i = sdr; sdr_fall_i = fall;
    ddr_phase_i = ph; lsb_first_i = lsb; twos_comp_i = twos;
    for (int win = 0; win < BITS; win++) begin
      @(negedge clk);
      chk("R1 fclk", 32'(fclk_o), 32'(win < BITS / 2));
      chk(sdr ? "R6 bclk" : "R5 bclk", 32'(bclk_o), 32'(exp_bclk(win, sdr, fall, ph)));
      for (int c = 0; c < NCH; c++) begin
        logic e = exp_bit(smp[c*BITS +: BITS], win, lsb, twos, pd[c]);
        if (pd[c])     chk("R7 R2 data", 32'(data_o[c]), 32'(e));
        else if (twos) chk("R4 R2 data", 32'(data_o[c]), 32'(e));
        else           chk("R3 R2 data", 32'(data_o[c]), 32'(e));
      end
      if (win < BITS - 1) junk();
    end
  endtask

  function automatic logic [NCH*BITS-1:0] fill(logic [11:0] v);
    logic [NCH*BITS-1:0] r;
    for (int c = 0; c < NCH; c++) r[c*BITS +: BITS] = v;
    return r;
  endfunction

  function automatic logic [NCH*BITS-1:0] rnd_smp();
    logic [NCH*BITS-1:0] r;
    for (int c = 0; c < NCH; c++) r[c*BITS +: BITS] = 12'($urandom);
    return r;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8: reset state, window 11 with default configuration
    junk();
    #1;
    chk("R8 data", 32'(data_o), 32'(0));
    chk("R8 fclk", 32'(fclk_o), 32'(0));
    chk("R8 bclk", 32'(bclk_o), 32'(exp_bclk(11, 1'b0, 1'b0, 2'd0)));
    @(negedge clk);
    rst_ni = 1'b1;
    // R8: first edge after release captures these
    run_frame(fill(12'h800), '0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    run_frame(fill(12'h7FF), '0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1);
    run_frame(fill(12'h800), '0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1);
    run_frame(fill(12'hA5C), '0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0);
    run_frame(rnd_smp(), 8'hA5, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    run_frame(rnd_smp(), 8'hFF, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1);
    run_frame(fill(12'hFFF), 8'h01, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1);
    for (int f = 0; f < 60; f++)
      run_frame(rnd_smp(), NCH'($urandom), 1'($urandom), 1'($urandom),
                2'($urandom), 1'($urandom), 1'($urandom));
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule